// File: doc/BRIEF.md
# Operand-Gathering Computation Unit Manager

This block sits between an issue stage, a register file and an execution unit. It accepts a single-cycle issue pulse that carries an operation. It then collects the source operands that operation needs. Each source port has its own request/grant handshake. A port's request stays raised until the register file answers with a one-cycle grant, and the operand data is captured in that grant cycle. Ports complete independently, in any order and after any delay.

Some operand reads can be suppressed at issue. A zero-A flag replaces operand 0 with zero. An immediate-valid flag replaces operand 1 with the issued immediate. A per-port skip mask replaces any port's operand with zero. A suppressed port never raises a request.

Once every requested operand has arrived, the operands go to the execution unit over a valid/ready interface. The unit accepts the execution result into a holding register and raises a write request. It drives the held result on `dest_o` until the write grant arrives. `busy_o` covers the whole sequence from issue to write-back, so a result is never dropped. Issue pulses that arrive while busy are ignored.

Top module: `opgather_unit`

## Requirements
- R1: While reset is applied and after it is released, `busy_o`, every `rd_req_o` bit, `exe_valid_o`, `exe_res_ready_o` and `wr_req_o` are low.
- R2: An `issue_i` pulse while idle is accepted: `busy_o` is high from the next cycle on. `busy_o` never rises without an accepted issue, and it stays low while no issue arrives.
- R3: For every port that is not suppressed, `rd_req_o[i]` goes high in the cycle after the accepted issue. It then stays high until a cycle in which `rd_grant_i[i]` is high.
- R4: `src_data_i[i*16 +: 16]` is captured in the cycle where `rd_grant_i[i]` and `rd_req_o[i]` are both high. This may be the very cycle the request rises. `rd_req_o[i]` is low in the following cycle.
- R5: With the zero-A flag set at issue, port 0 raises no request and operand 0 (bits [15:0] of `exe_opnd_o`) is zero before any inversion.
- R6: With the immediate-valid flag set at issue, port 1 raises no request and operand 1 (bits [31:16]) equals the issued immediate. The immediate takes precedence over the skip-mask bit of port 1.
- R7: A set `rd_skip_i[i]` bit at issue suppresses the request of port i. Its operand is zero, unless R6 applies.
- R8: With the invert flag set at issue, operand 0 is presented bitwise inverted, after any zero substitution.
- R9: `exe_valid_o` is high only once no read request is pending. It carries the issued operation type on `exe_type_o`. It stays high with stable operands until the cycle where `exe_ready_i` is high.
- R10: After the operands are accepted, `exe_res_ready_o` is high until a result is taken with `exe_res_valid_i`. `wr_req_o` then rises in the next cycle and holds that result on `dest_o`. After the cycle with `wr_grant_i` high, `busy_o` is low.
- R11: An `issue_i` pulse while busy is ignored. It changes neither the operation in flight nor its result, and it starts no later operation.
- R12: Operands may arrive in either order with independent delays. With partners answering within a few cycles, an operation ends within 50 cycles of issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | One-cycle issue pulse |
| op_type_i | input | OPC_W (4) | Operation type, passed to the execution unit |
| op_invert_i | input | 1 | Invert operand 0 |
| op_imm_i | input | DATA_W (16) | Immediate value for operand 1 |
| op_imm_ok_i | input | 1 | Use the immediate for operand 1 |
| op_zero_a_i | input | 1 | Use zero for operand 0 |
| rd_skip_i | input | NUM_SRC (2) | Per-port read suppression, held while busy |
| busy_o | output | 1 | Operation in flight |
| rd_req_o | output | NUM_SRC | Per-port read request |
| rd_grant_i | input | NUM_SRC | Per-port read grant pulse |
| src_data_i | input | NUM_SRC*DATA_W | Source data, port i at bits [i*DATA_W +: DATA_W] |
| exe_valid_o | output | 1 | Operands valid to the execution unit |
| exe_ready_i | input | 1 | Execution unit accepts operands |
| exe_type_o | output | OPC_W | Latched operation type |
| exe_opnd_o | output | NUM_SRC*DATA_W | Gathered operands, port i at bits [i*DATA_W +: DATA_W] |
| exe_res_valid_i | input | 1 | Execution result valid |
| exe_res_ready_o | output | 1 | Unit ready to take the result |
| exe_res_i | input | DATA_W | Execution result |
| wr_req_o | output | 1 | Write-back request |
| wr_grant_i | input | 1 | Write-back grant pulse |
| dest_o | output | DATA_W | Held result for write-back |

## Verification
The assertions check the handshake rules in every cycle. A request rises only after an accepted issue and holds until granted. A grant clears its request one cycle later. `busy_o` rises only after an issue, and it is idle with no requests or valids outstanding. The operand offer holds until it is accepted, and the write request holds until it is granted.

Only the bench scenarios can show that the right values flow through. These cover the zero, immediate, mask and invert substitutions, capture of data presented only in the grant cycle, and the ordering and delays of grants. They also cover the rejection of an issue made while busy, and the result reaching `dest_o` unchanged.

// File: rtl/opgather_pkg.sv
package opgather_pkg;

  // Phase of the back half of an operation (execute and write-back).
  typedef enum logic [1:0] {
    PH_GATHER  = 2'd0,  // waiting for operands, or idle
    PH_COLLECT = 2'd1,  // operands accepted, waiting for the result
    PH_WRITE   = 2'd2   // result held, write-back requested
  } og_phase_e;

endpackage

// File: rtl/og_rst_sync.sv
module og_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/og_issue_ctl.sv
module og_issue_ctl #(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [OPC_W-1:0] type_i,
  input  logic             invert_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             start_o,
  output logic [OPC_W-1:0] type_o,
  output logic             invert_o
);

  logic             busy_q, busy_d;
  logic [OPC_W-1:0] type_q;
  logic             invert_q;

  // An issue is taken only while idle.
  assign start_o = issue_i & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    if (start_o) begin
      busy_d = 1'b1;
    end else if (done_i) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      type_q   <= '0;
      invert_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (start_o) begin
        type_q   <= type_i;
        invert_q <= invert_i;
      end
    end
  end

  assign busy_o   = busy_q;
  assign type_o   = type_q;
  assign invert_o = invert_q;

  // R2
  busy_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(issue_i));

  // R11
  no_relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i) |=> ($stable(type_q) && $stable(invert_q)));

endmodule

// File: rtl/og_src_slot.sv
module og_src_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              skip_i,
  input  logic [DATA_W-1:0] subst_i,
  input  logic              grant_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic [DATA_W-1:0] opnd_o
);

  logic              req_q, req_d;
  logic [DATA_W-1:0] opnd_q, opnd_d;
  logic              take;
  logic              opnd_en;

  assign take = req_q & grant_i;

  always_comb begin
    req_d = req_q;
    if (start_i) begin
      req_d = ~skip_i;
    end else if (take) begin
      req_d = 1'b0;
    end
    opnd_en = start_i | take;
    opnd_d  = start_i ? subst_i : data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      opnd_q <= '0;
    end else begin
      req_q <= req_d;
      if (opnd_en) begin
        opnd_q <= opnd_d;
      end
    end
  end

  assign req_o  = req_q;
  assign opnd_o = opnd_q;

  // R3
  req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(start_i));

  // R3
  req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !grant_i) |=> req_q);

  // R4
  req_drops_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && grant_i) |=> !req_q);

  // R4
  capture_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && grant_i) |=> (opnd_q == $past(data_i)));

endmodule

// File: rtl/og_result_stage.sv
module og_result_stage
  import opgather_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              all_in_i,
  input  logic              exe_ready_i,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              wr_grant_i,
  output logic              exe_valid_o,
  output logic              res_ready_o,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] dest_o,
  output logic              done_o
);

  og_phase_e         ph_q, ph_d;
  logic [DATA_W-1:0] res_q;
  logic              res_en;

  always_comb begin
    ph_d        = ph_q;
    exe_valid_o = 1'b0;
    res_ready_o = 1'b0;
    wr_req_o    = 1'b0;
    done_o      = 1'b0;
    res_en      = 1'b0;
    unique case (ph_q)
      PH_GATHER: begin
        exe_valid_o = busy_i & all_in_i;
        if (exe_valid_o && exe_ready_i) begin
          ph_d = PH_COLLECT;
        end
      end
      PH_COLLECT: begin
        res_ready_o = 1'b1;
        if (res_valid_i) begin
          res_en = 1'b1;
          ph_d   = PH_WRITE;
        end
      end
      PH_WRITE: begin
        wr_req_o = 1'b1;
        if (wr_grant_i) begin
          done_o = 1'b1;
          ph_d   = PH_GATHER;
        end
      end
      default: ph_d = PH_GATHER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_GATHER;
      res_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (res_en) begin
        res_q <= res_i;
      end
    end
  end

  assign dest_o = res_q;

  // R9
  offer_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid_o && !exe_ready_i) |=> exe_valid_o);

  // R10
  wr_req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_grant_i) |=> (wr_req_o && $stable(dest_o)));

  // R10
  result_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready_o && res_valid_i) |=> (wr_req_o && dest_o == $past(res_i)));

endmodule

// File: rtl/opgather_unit.sv
module opgather_unit #(
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 2,
  parameter int OPC_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue_i,
  input  logic [OPC_W-1:0]          op_type_i,
  input  logic                      op_invert_i,
  input  logic [DATA_W-1:0]         op_imm_i,
  input  logic                      op_imm_ok_i,
  input  logic                      op_zero_a_i,
  input  logic [NUM_SRC-1:0]        rd_skip_i,
  output logic                      busy_o,
  output logic [NUM_SRC-1:0]        rd_req_o,
  input  logic [NUM_SRC-1:0]        rd_grant_i,
  input  logic [NUM_SRC*DATA_W-1:0] src_data_i,
  output logic                      exe_valid_o,
  input  logic                      exe_ready_i,
  output logic [OPC_W-1:0]          exe_type_o,
  output logic [NUM_SRC*DATA_W-1:0] exe_opnd_o,
  input  logic                      exe_res_valid_i,
  output logic                      exe_res_ready_o,
  input  logic [DATA_W-1:0]         exe_res_i,
  output logic                      wr_req_o,
  input  logic                      wr_grant_i,
  output logic [DATA_W-1:0]         dest_o
);

  localparam int OPND_W = NUM_SRC * DATA_W;

  logic              rst_n_s;
  logic              start;
  logic              done;
  logic              busy;
  logic              invert_q;
  logic              all_in;
  logic [NUM_SRC-1:0] skip_w;
  logic [NUM_SRC-1:0] req_w;
  logic [OPND_W-1:0]  subst_w;
  logic [OPND_W-1:0]  opnd_w;

  og_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  og_issue_ctl #(.OPC_W(OPC_W)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .issue_i  (issue_i),
    .type_i   (op_type_i),
    .invert_i (op_invert_i),
    .done_i   (done),
    .busy_o   (busy),
    .start_o  (start),
    .type_o   (exe_type_o),
    .invert_o (invert_q)
  );

  // Per-port suppression and substitute value, decided in the issue cycle.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_port
    if (i == 0) begin : g_a
      assign skip_w[i] = op_zero_a_i | rd_skip_i[i];
      assign subst_w[i*DATA_W +: DATA_W] = '0;
      assign exe_opnd_o[i*DATA_W +: DATA_W] = invert_q ? ~opnd_w[i*DATA_W +: DATA_W]
                                                       :  opnd_w[i*DATA_W +: DATA_W];
    end else if (i == 1) begin : g_b
      assign skip_w[i] = op_imm_ok_i | rd_skip_i[i];
      assign subst_w[i*DATA_W +: DATA_W] = op_imm_ok_i ? op_imm_i : '0;
      assign exe_opnd_o[i*DATA_W +: DATA_W] = opnd_w[i*DATA_W +: DATA_W];
    end else begin : g_c
      assign skip_w[i] = rd_skip_i[i];
      assign subst_w[i*DATA_W +: DATA_W] = '0;
      assign exe_opnd_o[i*DATA_W +: DATA_W] = opnd_w[i*DATA_W +: DATA_W];
    end

    og_src_slot #(.DATA_W(DATA_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .start_i (start),
      .skip_i  (skip_w[i]),
      .subst_i (subst_w[i*DATA_W +: DATA_W]),
      .grant_i (rd_grant_i[i]),
      .data_i  (src_data_i[i*DATA_W +: DATA_W]),
      .req_o   (req_w[i]),
      .opnd_o  (opnd_w[i*DATA_W +: DATA_W])
    );
  end

  assign all_in = ~|req_w;

  og_result_stage #(.DATA_W(DATA_W)) u_result (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .busy_i      (busy),
    .all_in_i    (all_in),
    .exe_ready_i (exe_ready_i),
    .res_valid_i (exe_res_valid_i),
    .res_i       (exe_res_i),
    .wr_grant_i  (wr_grant_i),
    .exe_valid_o (exe_valid_o),
    .res_ready_o (exe_res_ready_o),
    .wr_req_o    (wr_req_o),
    .dest_o      (dest_o),
    .done_o      (done)
  );

  assign busy_o   = busy;
  assign rd_req_o = req_w;

  // R9
  valid_after_gather_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    exe_valid_o |-> (req_w == '0));

  // R10
  idle_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_req_o && wr_grant_i) |=> !busy_o);

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_o |-> (req_w == '0 && !wr_req_o && !exe_valid_o && !exe_res_ready_o));

  // R9
  operands_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (exe_valid_o && !exe_ready_i) |=> $stable(exe_opnd_o));

endmodule

// File: tb/test_opgather_unit.sv
module test_opgather_unit;

  localparam int W = 16;
  localparam int N = 2;
  localparam int T = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           issue = 1'b0;
  logic [T-1:0]   op_type = '0;
  logic           op_inv = 1'b0;
  logic [W-1:0]   op_imm = '0;
  logic           op_iok = 1'b0;
  logic           op_za = 1'b0;
  logic [N-1:0]   skip = '0;
  logic           busy;
  logic [N-1:0]   rd_req;
  logic [N-1:0]   rd_grant = '0;
  logic [N*W-1:0] src_data = '0;
  logic           exe_valid;
  logic           exe_ready = 1'b0;
  logic [T-1:0]   exe_type;
  logic [N*W-1:0] exe_opnd;
  logic           res_valid = 1'b0;
  logic           res_ready;
  logic [W-1:0]   res_data = '0;
  logic           wr_req;
  logic           wr_grant = 1'b0;
  logic [W-1:0]   dest;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  opgather_unit i_opgather_unit (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_type_i(op_type),
    .op_invert_i(op_inv), .op_imm_i(op_imm), .op_imm_ok_i(op_iok),
    .op_zero_a_i(op_za), .rd_skip_i(skip), .busy_o(busy),
    .rd_req_o(rd_req), .rd_grant_i(rd_grant), .src_data_i(src_data),
    .exe_valid_o(exe_valid), .exe_ready_i(exe_ready), .exe_type_o(exe_type),
    .exe_opnd_o(exe_opnd), .exe_res_valid_i(res_valid),
    .exe_res_ready_o(res_ready), .exe_res_i(res_data), .wr_req_o(wr_req),
    .wr_grant_i(wr_grant), .dest_o(dest)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Expected operand 0: zero substitution, then inversion (R5, R7, R8).
  function automatic logic [W-1:0] exp_a(logic [W-1:0] a, bit za, bit sk, bit inv);
    logic [W-1:0] v;
    v = (za || sk) ? '0 : a;
    return inv ? ~v : v;
  endfunction

  // Expected operand 1: immediate wins over mask (R6, R7).
  function automatic logic [W-1:0] exp_b(logic [W-1:0] b, bit iok, logic [W-1:0] imm, bit sk);
    if (iok) return imm;
    if (sk) return '0;
    return b;
  endfunction

  // Bench execution-unit model: type 1 adds, others subtract.
  function automatic logic [W-1:0] alu_model(logic [T-1:0] t, logic [W-1:0] a, logic [W-1:0] b);
    return (t == 4'd1) ? a + b : a - b;
  endfunction

  task automatic serve_port(input int p, input logic [W-1:0] val, input int dly, input bit supp);
    if (supp) begin
      int bad = 0;
      while (busy) begin
        if (rd_req[p]) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R7 suppressed port raised request", bad, 0);
    end else begin
      chk(rd_req[p] == 1'b1, "R3 request one cycle after issue", rd_req[p], 1);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(rd_req[p] == 1'b1, "R3 request held until grant", rd_req[p], 1);
      end
      rd_grant[p] = 1'b1;
      src_data[p*W +: W] = val;
      @(negedge clk);
      rd_grant[p] = 1'b0;
      src_data[p*W +: W] = W'($urandom);
      chk(rd_req[p] == 1'b0, "R4 request low after grant", rd_req[p], 0);
    end
  endtask

  task automatic serve_exe(input logic [T-1:0] typ, input logic [W-1:0] ea,
                           input logic [W-1:0] eb, input int dx, input int dr);
    int t = 0;
    logic [N*W-1:0] snap;
    while (!exe_valid && t < 60) begin
      @(negedge clk);
      t++;
    end
    chk(exe_valid == 1'b1, "R9 operands offered", exe_valid, 1);
    chk(rd_req == '0, "R9 offer only after all reads", rd_req, 0);
    chk(exe_type == typ, "R9 operation type", exe_type, typ);
    chk(exe_opnd[W-1:0] == ea, "R5/R8 operand 0", exe_opnd[W-1:0], ea);
    chk(exe_opnd[2*W-1:W] == eb, "R6 operand 1", exe_opnd[2*W-1:W], eb);
    snap = exe_opnd;
    for (int k = 0; k < dx; k++) begin
      @(negedge clk);
      chk(exe_valid && exe_opnd == snap, "R9 offer held until ready", exe_opnd, snap);
    end
    exe_ready = 1'b1;
    @(negedge clk);
    exe_ready = 1'b0;
    chk(res_ready == 1'b1, "R10 result ready after accept", res_ready, 1);
    for (int k = 0; k < dr; k++) @(negedge clk);
    res_valid = 1'b1;
    res_data = alu_model(typ, ea, eb);
    @(negedge clk);
    res_valid = 1'b0;
    res_data = W'($urandom);
  endtask

  task automatic serve_wr(input logic [W-1:0] exp, input int dw);
    int t = 0;
    while (!wr_req && t < 80) begin
      @(negedge clk);
      t++;
    end
    chk(wr_req == 1'b1, "R10 write request", wr_req, 1);
    for (int k = 0; k < dw; k++) @(negedge clk);
    wr_grant = 1'b1;
    chk(dest == exp, "R10 result on dest", dest, exp);
    @(negedge clk);
    wr_grant = 1'b0;
    chk(busy == 1'b0, "R10 busy low after grant", busy, 0);
  endtask

  task automatic poke_issue();
    repeat (2) @(negedge clk);
    issue = 1'b1;
    op_type = 4'd1; op_inv = 1'b1; op_za = 1'b1; op_iok = 1'b1; op_imm = 16'h7777;
    @(negedge clk);
    issue = 1'b0;
    op_type = '0; op_inv = 1'b0; op_za = 1'b0; op_iok = 1'b0; op_imm = '0;
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [T-1:0] typ,
                        input bit inv, input bit za, input bit iok, input logic [W-1:0] imm,
                        input logic [N-1:0] sk, input int d0, input int d1, input int dx,
                        input int dr, input int dw, input bit poke);
    logic [W-1:0] ea, eb, er;
    int t0;
    bit s0, s1;
    ea = exp_a(a, za, sk[0], inv);
    eb = exp_b(b, iok, imm, sk[1]);
    er = alu_model(typ, ea, eb);
    s0 = za | sk[0];
    s1 = iok | sk[1];
    chk(busy == 1'b0, "R2 idle before issue", busy, 0);
    skip = sk;
    issue = 1'b1;
    op_type = typ; op_inv = inv; op_za = za; op_iok = iok; op_imm = imm;
    t0 = cyc;
    @(negedge clk);
    issue = 1'b0;
    op_type = 4'(~typ); op_inv = ~inv; op_za = ~za; op_iok = ~iok; op_imm = ~imm;
    chk(busy == 1'b1, "R2 busy after issue", busy, 1);
    fork
      serve_port(0, a, d0, s0);
      serve_port(1, b, d1, s1);
      serve_exe(typ, ea, eb, dx, dr);
      serve_wr(er, dw);
      if (poke) poke_issue();
    join
    chk((cyc - t0) <= 50, "R12 operation within 50 cycles", cyc - t0, 50);
    skip = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy && rd_req == '0, "R11 no stray operation after end", {busy, rd_req}, 0);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(!busy && rd_req == '0 && !exe_valid && !wr_req && !res_ready,
        "R1 quiet in reset", {busy, rd_req, exe_valid, wr_req, res_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && rd_req == '0 && !exe_valid && !wr_req && !res_ready,
        "R1 quiet after reset", {busy, rd_req, exe_valid, wr_req, res_ready}, 0);
    // R12: A immediately, B two cycles later
    run_op(16'd13, 16'd2, 4'd1, 0, 0, 0, 16'd0, 2'b00, 0, 2, 0, 0, 0, 0);
    // R12: B first, A later, delayed write
    run_op(16'd3, 16'd4, 4'd2, 0, 0, 0, 16'd0, 2'b00, 2, 0, 1, 1, 2, 0);
    // R5 R6: no reads at all
    run_op(16'd5, 16'd2, 4'd1, 0, 1, 1, 16'd8, 2'b00, 0, 2, 0, 0, 0, 0);
    // R6: immediate only
    run_op(16'd5, 16'd2, 4'd1, 0, 0, 1, 16'd8, 2'b00, 2, 0, 2, 0, 2, 0);
    // R8: inverted A gives -6 + 2
    run_op(16'd5, 16'd2, 4'd1, 1, 0, 0, 16'd0, 2'b00, 1, 2, 0, 1, 0, 0);
    // R5: zero A
    run_op(16'd5, 16'd2, 4'd1, 0, 1, 0, 16'd0, 2'b00, 2, 0, 1, 0, 1, 0);
    // R7: mask both ports, and mask plus immediate
    run_op(16'h1234, 16'h4321, 4'd3, 0, 0, 0, 16'd0, 2'b11, 0, 0, 0, 0, 0, 0);
    run_op(16'h1234, 16'h4321, 4'd1, 0, 0, 1, 16'h00aa, 2'b10, 1, 0, 0, 0, 0, 0);
    run_op(16'h1234, 16'h4321, 4'd1, 1, 0, 0, 16'd0, 2'b01, 0, 3, 0, 0, 0, 0);
    // R11: issue while busy is ignored
    run_op(16'd100, 16'd30, 4'd2, 0, 0, 0, 16'd0, 2'b00, 3, 3, 2, 2, 3, 1);
    for (int k = 0; k < 40; k++) begin
      run_op(W'($urandom), W'($urandom), T'($urandom_range(0, 3)),
             bit'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
             ($urandom_range(0, 3) == 0), W'($urandom),
             ($urandom_range(0, 3) == 0) ? N'($urandom) : '0,
             $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
             $urandom_range(0, 3), $urandom_range(0, 3), ($urandom_range(0, 7) == 0));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule